// File: doc/BRIEF.md
# Serial Interrupt Bus Device Agent

This block is the device end of a shared, single-wire serial interrupt line. The line is open-drain and runs on the host bus clock. The block samples the line every clock. It recognises the host's start frame and then counts three-clock slots. In the sample clock of each slot whose request is high, it pulls the line low. Slot 3 can also carry a system-management request, and an enable bit routes that request onto the bus. A second enable bit routes it to a dedicated pin.

When the frames end, the block measures how long the host holds the line low for the stop pulse. That length sets the mode of the next cycle. In quiet mode the block may open a new cycle by itself with a one-clock low, but only after one of its requests has changed since it was last sent. In continuous mode only the host opens cycles. The pad itself is outside the block: `ser_oe_o` enables the driver and `ser_do_o` gives the level it drives.

Top module: `serirq_agent`

## Requirements
- R1: While reset is active and after it is released, `ser_oe_o` is 0 and the mode is continuous. A request that is already pending at reset release does not make the block drive the line before a host cycle.
- R2: A low on the line that lasts 4 or more clocks, followed by a high, counts as a start frame. The first high clock after that low is clock 1. Slot n is then sampled in clock 3n-1.
- R3: In the sample clock of a slot whose request is high, the block drives low (`ser_oe_o`=1, `ser_do_o`=0). In the next clock it drives high (`ser_oe_o`=1, `ser_do_o`=1). In the clock after that it releases the line. A slot whose request is low is left released.
- R4: Slot 1 is always left released, and `irq_i[0]` has no effect on the bus. For n ≥ 2, slot n carries `irq_i[n-1]`; for example, slot 14 carries `irq_i[13]`.
- R5: Slot 3 carries `irq_i[2]` OR (`smi_i` AND `smi_bus_en_i`).
- R6: `smi_pin_o` equals `smi_i` AND `smi_pin_en_i`, whatever the value of `smi_bus_en_i`.
- R7: After the turnaround clock of slot 16 (clock 49), the next low pulse decides the mode. A low of exactly 2 clocks selects quiet mode. A low of exactly 3 clocks selects continuous mode.
- R8: In continuous mode the block never drives the line outside the slots of a host-opened cycle.
- R9: In quiet mode the block drives a self-start low for exactly one clock and then releases the line. It may do so only while an effective slot request differs from the value last sent in that slot, and only if the line was high in the previous clock. The earliest clock for this low is two clocks after the first high clock that ends the stop pulse.
- R10: Once all request changes have been sent, the block does not self-start again in quiet mode.
- R11: The block never drives low in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Request levels; bit k is sent in slot k+1, bit 0 is unused |
| smi_i | input | 1 | System-management request |
| smi_bus_en_i | input | 1 | Places `smi_i` into slot 3 |
| smi_pin_en_i | input | 1 | Routes `smi_i` to `smi_pin_o` |
| ser_i | input | 1 | Sampled level of the serial line |
| ser_oe_o | output | 1 | Pad drive enable |
| ser_do_o | output | 1 | Level driven while enabled |
| smi_pin_o | output | 1 | Dedicated management-interrupt output |

## Verification
Host cycles are run with several request patterns: a mixed pattern with bit 0 set, a single request in slot 14, and the management request with each routing enable on its own. Comparing the sampled slot bits against the expected vector tells a wrong slot index apart from a missing recovery or release clock. Stop pulses of 2 and 3 clocks are each followed by an idle watch. In these watches a changed request, an unchanged request and a change to bit 0 alone must start a cycle, stay silent and stay silent, respectively. The exact clock of the self-start low is checked both right after a stop pulse and after a long idle, which separates a correct start gap from one that is off by a clock.

// File: rtl/serirq_pkg.sv
package serirq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_FRAMES, PH_STOP} phase_e;
  typedef enum logic {MODE_CONT, MODE_QUIET} mode_e;
endpackage

// File: rtl/serirq_frame_tracker.sv
module serirq_frame_tracker
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS      = 16,
  parameter int START_MIN      = 4,
  parameter int STOP_QUIET_LEN = 2,
  parameter int STOP_CONT_LEN  = 3,
  parameter int START_GAP      = 2,
  localparam int SLOT_W = $clog2(NUM_SLOTS + 1),
  localparam int GAP_W  = $clog2(START_GAP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output phase_e            phase_d_o,
  output phase_e            phase_q_o,
  output mode_e             mode_d_o,
  output mode_e             mode_q_o,
  output logic [SLOT_W-1:0] slot_d_o,
  output logic [SLOT_W-1:0] slot_q_o,
  output logic [1:0]        sub_d_o,
  output logic [1:0]        sub_q_o,
  output logic [GAP_W-1:0]  gap_d_o,
  output logic [GAP_W-1:0]  gap_q_o
);
  localparam int LOW_W = $clog2(START_MIN + 1);

  logic [LOW_W-1:0]  low_q, low_d;
  phase_e            phase_q, phase_d;
  mode_e             mode_q, mode_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [1:0]        sub_q, sub_d;
  logic [GAP_W-1:0]  gap_q, gap_d;

  always_comb begin
    low_d   = low_q;
    phase_d = phase_q;
    mode_d  = mode_q;
    slot_d  = slot_q;
    sub_d   = sub_q;
    gap_d   = gap_q;
    // slot position advances every clock while frames run
    if (phase_q == PH_FRAMES) begin
      if (sub_q == 2'd2) begin
        sub_d = 2'd0;
        if (slot_q == SLOT_W'(NUM_SLOTS)) begin
          phase_d = PH_STOP;
          slot_d  = '0;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
    if (!line_i) begin
      if (low_q < LOW_W'(START_MIN)) low_d = low_q + 1'b1;
    end else begin
      low_d = '0;
      if (phase_q == PH_IDLE && gap_q < GAP_W'(START_GAP)) gap_d = gap_q + 1'b1;
      if (low_q >= LOW_W'(START_MIN)) begin
        phase_d = PH_FRAMES;
        slot_d  = SLOT_W'(1);
        sub_d   = 2'd0;
        gap_d   = '0;
      end else if (phase_q == PH_STOP && low_q == LOW_W'(STOP_QUIET_LEN)) begin
        phase_d = PH_IDLE;
        mode_d  = MODE_QUIET;
        gap_d   = GAP_W'(1);
      end else if (phase_q == PH_STOP && low_q == LOW_W'(STOP_CONT_LEN)) begin
        phase_d = PH_IDLE;
        mode_d  = MODE_CONT;
        gap_d   = GAP_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q   <= '0;
      phase_q <= PH_IDLE;
      mode_q  <= MODE_CONT;
      slot_q  <= '0;
      sub_q   <= '0;
      gap_q   <= '0;
    end else begin
      low_q   <= low_d;
      phase_q <= phase_d;
      mode_q  <= mode_d;
      slot_q  <= slot_d;
      sub_q   <= sub_d;
      gap_q   <= gap_d;
    end
  end

  assign phase_d_o = phase_d;
  assign phase_q_o = phase_q;
  assign mode_d_o  = mode_d;
  assign mode_q_o  = mode_q;
  assign slot_d_o  = slot_d;
  assign slot_q_o  = slot_q;
  assign sub_d_o   = sub_d;
  assign sub_q_o   = sub_q;
  assign gap_d_o   = gap_d;
  assign gap_q_o   = gap_q;
endmodule

// File: rtl/serirq_req_map.sv
module serirq_req_map #(
  parameter int NUM_SLOTS = 16,
  parameter int SMI_SLOT  = 3
) (
  input  logic [NUM_SLOTS-1:0] irq_i,
  input  logic                 smi_i,
  input  logic                 smi_bus_en_i,
  input  logic                 smi_pin_en_i,
  output logic [NUM_SLOTS-1:0] slot_req_o,
  output logic                 smi_pin_o
);
  logic unused_irq0;
  assign unused_irq0 = irq_i[0];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g == 0) begin : g_empty
      assign slot_req_o[g] = 1'b0;
    end else if (g == SMI_SLOT - 1) begin : g_smi
      assign slot_req_o[g] = irq_i[g] | (smi_i & smi_bus_en_i);
    end else begin : g_irq
      assign slot_req_o[g] = irq_i[g];
    end
  end

  assign smi_pin_o = smi_i & smi_pin_en_i;
endmodule

// File: rtl/serirq_slot_driver.sv
module serirq_slot_driver
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int START_GAP = 2,
  localparam int SLOT_W = $clog2(NUM_SLOTS + 1),
  localparam int GAP_W  = $clog2(START_GAP + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_i,
  input  logic [NUM_SLOTS-1:0] req_i,
  input  phase_e               phase_d_i,
  input  mode_e                mode_d_i,
  input  logic [SLOT_W-1:0]    slot_d_i,
  input  logic [1:0]           sub_d_i,
  input  logic [GAP_W-1:0]     gap_d_i,
  output logic                 oe_o,
  output logic                 do_o
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic [NUM_SLOTS-1:0] sent_q, sent_d;
  logic                 start_q, start_d;
  logic                 oe_q, oe_d, do_q, do_d;
  logic [IDX_W-1:0]     idx;
  logic                 pending;

  assign idx     = IDX_W'(slot_d_i - SLOT_W'(1));
  assign pending = |(req_i ^ sent_q);

  // decisions use the tracker's state for the clock just sampled; outputs apply to the next clock
  always_comb begin
    oe_d    = 1'b0;
    do_d    = 1'b1;
    sent_d  = sent_q;
    start_d = start_q;
    if (phase_d_i != PH_IDLE) start_d = 1'b0;
    if (phase_d_i == PH_FRAMES) begin
      if (sub_d_i == 2'd0 && slot_d_i != '0) begin
        sent_d[idx] = req_i[idx];
        if (req_i[idx]) begin
          oe_d = 1'b1;
          do_d = 1'b0;
        end
      end else if (sub_d_i == 2'd1 && oe_q && !do_q) begin
        oe_d = 1'b1;
        do_d = 1'b1;
      end
    end else if (phase_d_i == PH_IDLE && mode_d_i == MODE_QUIET &&
                 gap_d_i >= GAP_W'(START_GAP) && line_i && pending && !start_q) begin
      oe_d    = 1'b1;
      do_d    = 1'b0;
      start_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sent_q  <= '0;
      start_q <= 1'b0;
      oe_q    <= 1'b0;
      do_q    <= 1'b1;
    end else begin
      sent_q  <= sent_d;
      start_q <= start_d;
      oe_q    <= oe_d;
      do_q    <= do_d;
    end
  end

  assign oe_o = oe_q;
  assign do_o = do_q;
endmodule

// File: rtl/serirq_agent.sv
module serirq_agent
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS      = 16,
  parameter int START_MIN      = 4,
  parameter int STOP_QUIET_LEN = 2,
  parameter int STOP_CONT_LEN  = 3,
  parameter int START_GAP      = 2,
  parameter int SMI_SLOT       = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] irq_i,
  input  logic                 smi_i,
  input  logic                 smi_bus_en_i,
  input  logic                 smi_pin_en_i,
  input  logic                 ser_i,
  output logic                 ser_oe_o,
  output logic                 ser_do_o,
  output logic                 smi_pin_o
);
  localparam int SLOT_W = $clog2(NUM_SLOTS + 1);
  localparam int GAP_W  = $clog2(START_GAP + 1);

  logic [NUM_SLOTS-1:0] slot_req;
  phase_e               phase_d, trk_phase;
  mode_e                mode_d, trk_mode;
  logic [SLOT_W-1:0]    slot_d, trk_slot;
  logic [1:0]           sub_d, trk_sub;
  logic [GAP_W-1:0]     gap_d, trk_gap;

  serirq_req_map #(
    .NUM_SLOTS(NUM_SLOTS),
    .SMI_SLOT (SMI_SLOT)
  ) u_map (
    .irq_i       (irq_i),
    .smi_i       (smi_i),
    .smi_bus_en_i(smi_bus_en_i),
    .smi_pin_en_i(smi_pin_en_i),
    .slot_req_o  (slot_req),
    .smi_pin_o   (smi_pin_o)
  );

  serirq_frame_tracker #(
    .NUM_SLOTS     (NUM_SLOTS),
    .START_MIN     (START_MIN),
    .STOP_QUIET_LEN(STOP_QUIET_LEN),
    .STOP_CONT_LEN (STOP_CONT_LEN),
    .START_GAP     (START_GAP)
  ) u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (ser_i),
    .phase_d_o(phase_d),
    .phase_q_o(trk_phase),
    .mode_d_o (mode_d),
    .mode_q_o (trk_mode),
    .slot_d_o (slot_d),
    .slot_q_o (trk_slot),
    .sub_d_o  (sub_d),
    .sub_q_o  (trk_sub),
    .gap_d_o  (gap_d),
    .gap_q_o  (trk_gap)
  );

  serirq_slot_driver #(
    .NUM_SLOTS(NUM_SLOTS),
    .START_GAP(START_GAP)
  ) u_drv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (ser_i),
    .req_i    (slot_req),
    .phase_d_i(phase_d),
    .mode_d_i (mode_d),
    .slot_d_i (slot_d),
    .sub_d_i  (sub_d),
    .gap_d_i  (gap_d),
    .oe_o     (ser_oe_o),
    .do_o     (ser_do_o)
  );
endmodule

// File: rtl/serirq_agent_chk.sv
module serirq_agent_chk
  import serirq_pkg::*;
#(
  parameter int SLOT_W    = 5,
  parameter int GAP_W     = 2,
  parameter int START_GAP = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ser_oe_o,
  input logic              ser_do_o,
  input phase_e            trk_phase,
  input mode_e             trk_mode,
  input logic [SLOT_W-1:0] trk_slot,
  input logic [1:0]        trk_sub,
  input logic [GAP_W-1:0]  trk_gap
);
  AST_SINGLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_oe_o && !ser_do_o) |=> !(ser_oe_o && !ser_do_o)); // R11

  AST_RECOVERY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_oe_o && !ser_do_o && trk_phase == PH_FRAMES) |=> (ser_oe_o && ser_do_o)); // R3

  AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_oe_o && ser_do_o) |=> !ser_oe_o); // R3

  AST_SLOT1_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_phase == PH_FRAMES && trk_slot == SLOT_W'(1) && trk_sub == 2'd0) |-> !ser_oe_o); // R4

  AST_START_QUIET_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_phase == PH_IDLE && ser_oe_o && !ser_do_o) |->
      (trk_mode == MODE_QUIET && trk_gap >= GAP_W'(START_GAP))); // R9

  AST_IDLE_CONT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_phase == PH_IDLE && trk_mode == MODE_CONT) |-> !ser_oe_o); // R8
endmodule

bind serirq_agent serirq_agent_chk #(
  .SLOT_W   (SLOT_W),
  .GAP_W    (GAP_W),
  .START_GAP(START_GAP)
) u_chk (.*);

// File: tb/serirq_agent_test.sv
module serirq_agent_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        smi = 1'b0, smi_bus_en = 1'b0, smi_pin_en = 1'b0;
  logic        host_low = 1'b0;
  logic        ser, ser_oe, ser_do, smi_pin;
  int          checks = 0, errors = 0;
  int          mon_k = 0;
  bit          mon_end = 1'b0;
  logic [15:0] exp_q[$];
  logic [15:0] obs = '0;

  always #2 clk = ~clk;
  assign ser = !(host_low || (ser_oe && !ser_do));

  serirq_agent uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .smi_i(smi),
    .smi_bus_en_i(smi_bus_en), .smi_pin_en_i(smi_pin_en), .ser_i(ser),
    .ser_oe_o(ser_oe), .ser_do_o(ser_do), .smi_pin_o(smi_pin)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input bit low);
    @(negedge clk);
    host_low = low;
    mon_k    = 0;
    mon_end  = 1'b0;
  endtask

  // driver side of the scoreboard: expected slot vector from R4/R5
  task automatic push_expected();
    logic [15:0] e;
    e    = irq;
    e[0] = 1'b0;
    e[2] = irq[2] | (smi & smi_bus_en);
    exp_q.push_back(e);
  endtask

  task automatic host_frames();
    for (int k = 1; k <= 49; k++) begin
      tick(1'b0);
      mon_k   = k;
      mon_end = (k == 49);
    end
  endtask

  task automatic host_cycle();
    push_expected();
    repeat (4) tick(1'b1);
    host_frames();
  endtask

  task automatic host_stop(input int len);
    repeat (len) tick(1'b1);
  endtask

  task automatic idle_watch(input int n, output int first);
    first = 0;
    for (int i = 1; i <= n; i++) begin
      tick(1'b0);
      #1;
      if (ser_oe && !ser_do && first == 0) first = i;
    end
  endtask

  // wait for a device start, then extend the low as host and run the cycle
  task automatic device_cycle(input int exp_at, input string tag);
    int at;
    at = 0;
    for (int i = 1; i <= 8; i++) begin
      tick(1'b0);
      #1;
      if (ser_oe && !ser_do) begin
        at = i;
        break;
      end
    end
    chk(at == exp_at, tag, at, exp_at);
    if (at != 0) begin
      tick(1'b1);
      #1;
      chk(!ser_oe, "R9 self-start releases after one clock", ser_oe, 0);
      repeat (3) tick(1'b1);
      push_expected();
      host_frames();
    end
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_k > 0) begin
        if (mon_k % 3 == 2) obs[(mon_k + 1) / 3 - 1] = !ser;
        else if (mon_k % 3 == 0) begin
          if (obs[mon_k / 3 - 1])
            chk(ser_oe && ser_do, "R3 recovery clock drives high", {ser_oe, ser_do}, 2'b11);
        end else begin
          chk(!ser_oe, "R3 turnaround clock released", ser_oe, 0);
        end
      end
      if (mon_end) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected cycle", obs, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(obs == e, "R2 R3 R4 R5 slot vector", obs, e);
        end
        obs = '0;
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first;
    irq = 16'h0010;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(!ser_oe, "R1 released in reset", ser_oe, 0);
    end
    chk(!smi_pin, "R1 smi pin low", smi_pin, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_watch(10, first);
    chk(first == 0, "R1 R8 no start after reset", first, 0);

    // cycle A: mixed pattern with bit 0 set, then 3-clock stop
    irq = 16'hA5A5;
    host_cycle();
    host_stop(3);
    // cycle B: only slot 14
    irq = 16'h2000;
    host_cycle();
    host_stop(3);
    irq = 16'h0F0E;
    idle_watch(8, first);
    chk(first == 0, "R7 R8 continuous mode stays silent", first, 0);

    // cycle C: management request onto slot 3
    irq = 16'h0000;
    smi = 1'b1;
    smi_bus_en = 1'b1;
    #1;
    chk(!smi_pin, "R6 pin off without its enable", smi_pin, 0);
    host_cycle();
    host_stop(3);

    // cycle D: management request routed to pin only, 2-clock stop
    smi_bus_en = 1'b0;
    smi_pin_en = 1'b1;
    #1;
    chk(smi_pin, "R6 pin follows request", smi_pin, 1);
    host_cycle();
    host_stop(2);
    idle_watch(6, first);
    chk(first == 0, "R10 quiet mode, nothing changed", first, 0);
    irq[0] = 1'b1;
    idle_watch(6, first);
    chk(first == 0, "R4 bit 0 change ignored", first, 0);

    // change after long idle: start on the next clock
    irq = 16'h8002;
    device_cycle(1, "R9 self-start after long idle");
    irq = 16'h0408;
    host_stop(2);
    device_cycle(3, "R7 R9 earliest self-start after stop");
    host_stop(3);
    irq = 16'h1111;
    idle_watch(8, first);
    chk(first == 0, "R7 R8 back to continuous", first, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all cycles observed", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule